// File: doc/BRIEF.md
# Legacy I/O Interrupt Aggregator

This block is a byte-wide register window for legacy I/O. It collects up to eight device interrupt sources into a pending register, gates them with a primary enable mask and drives one upstream interrupt request. The same window also gives access to a secondary mask, a secondary status byte that always reads zero, two DMA mode registers, a port-B status byte and an RTC index/data pair. Timer channel registers and RTC data are not held here. Accesses to them go out on a side request/response port and wait for its acknowledge.

A host issues one access at a time on a valid/ready request channel: write flag, address, size code and write byte. The control state machine has three states. ST_IDLE accepts a request (`req_ready` high). Transition IDLE_TO_RESP is taken for local registers and for errors. Transition IDLE_TO_SIDE is taken for timer and RTC-data accesses. ST_SIDE holds `side_req` until `side_ack` arrives (SIDE_TO_RESP). ST_RESP presents `rsp_valid` for one cycle and returns to ST_IDLE (RESP_TO_IDLE). Device-side set and clear vectors update the pending register on every clock and need no handshake.

Offsets inside the 256-byte window: 0x20 primary status (read) and acknowledge (write), 0x21 primary mask, 0xA0 secondary status (read; a write is discarded), 0xA1 secondary mask, 0x40–0x42 timer channels 0–2, 0x43 timer control (write only), 0x70 RTC index (write only), 0x71 RTC data, 0x61 port B, 0x0B DMA mode 1, 0xD6 DMA mode 2. The discard-only offsets are 0x60, 0x08, 0xD0, 0x0A, 0xD4, 0x0D, 0xDA, 0x0F and 0xDE.

Top module: `lio_irq_agg`

## Requirements
- R1: A read or write gets `rsp_err`=1 and changes no state in these cases: the address lies outside the window (`req_addr[15:8]` differs from the base), the offset is unmapped, or the access is a byte read of a write-only offset (0x43, 0x70, 0x60, 0x08, 0xD0, 0x0A, 0xD4, 0x0D, 0xDA, 0x0F, 0xDE).
- R2: A byte write to 0x21 stores the inverse of the data as per-source enables, so a written 1 disables that source. A read of 0x21 returns the value last written.
- R3: `irq_out` is 1 exactly when (pending AND enable) is non-zero. It follows every mask write, set, clear and acknowledge one clock after that update.
- R4: A byte write to 0x20 clears the pending bit whose index is data[3:0]. Indices 8 to 15 change nothing.
- R5: `dev_set` ORs bits into pending and `dev_clr` removes bits from it. When both name the same bit in one cycle, the clear wins.
- R6: A byte read of 0x20 returns the pending byte. A 64-bit read (size code 3) is allowed only as a read of 0x20 and returns the pending byte zero-extended. Size codes 1 and 2, and every other 64-bit access, give `rsp_err`.
- R7: Offset 0xA0 always reads 0x00. Offset 0xA1 reads back the value last written and has no effect on `irq_out`.
- R8: A read of 0x61 returns 0x20 (bit 5) while `tmr2_high` is 1 and 0x00 otherwise. Writes to 0x61 are ignored.
- R9: A write to 0x70 latches an RTC index. A read or write of 0x71 issues a side request with `side_tgt`=1, `side_idx` equal to the latched index and `side_we` equal to the access direction. The read returns `side_rdata`.
- R10: A read or write of 0x40–0x42 issues a side request with `side_tgt`=0 and `side_idx` equal to the channel (0–2). A write to 0x43 issues a timer write with `side_idx`=3.
- R11: Writes to the discard-only offsets return without error and change nothing. Offsets 0x0B and 0xD6 store their written byte and read it back.
- R12: After reset the pending byte is 0, every source is disabled (0x21 reads 0xFF), both DMA modes read 0, the RTC index is 0 and `irq_out` is 0.
- R13: `req_ready` is high only in ST_IDLE. `rsp_valid` lasts exactly one cycle and is never high together with `req_ready`. `side_req` holds its fields stable until `side_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | 0 = byte, 3 = 64-bit, others invalid |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Response strobe, one cycle |
| rsp_err | output | 1 | Access rejected |
| rsp_rdata | output | 64 | Read data, zero-extended |
| dev_set | input | SRC_N | Device set vector |
| dev_clr | input | SRC_N | Device clear vector |
| irq_out | output | 1 | Upstream interrupt request |
| tmr2_high | input | 1 | Timer channel 2 output level |
| side_req | output | 1 | Side-port request held until acknowledge |
| side_tgt | output | 1 | 0 = timer, 1 = RTC |
| side_we | output | 1 | Side write |
| side_idx | output | 8 | Timer channel or RTC index |
| side_wdata | output | 8 | Side write byte |
| side_ack | input | 1 | Side-port completion |
| side_rdata | input | 8 | Side read byte |

## Verification
The assertions take two things for granted. First, `side_ack` is pulsed only while `side_req` is high. Second, the set and clear vectors may change on any cycle, whether or not a bus access is in flight. The bench's side responder raises the acknowledge a couple of cycles after it sees a request and drops it on the following cycle, so it never acknowledges an idle port. Device vectors are pulsed for a single cycle between accesses and, in the priority test, together with each other.

// File: rtl/lio_pkg.sv
package lio_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SIDE,
        ST_RESP
    } fsm_t;

    typedef enum logic [3:0] {
        AK_ERR,
        AK_PSTAT,
        AK_PACK,
        AK_PMASK,
        AK_SSTAT,
        AK_SMASK,
        AK_TMR,
        AK_TCTL,
        AK_RIDX,
        AK_RDATA,
        AK_PORTB,
        AK_DMODE1,
        AK_DMODE2,
        AK_DROP
    } kind_t;

    localparam logic [1:0] SZ_BYTE  = 2'd0;
    localparam logic [1:0] SZ_DWORD = 2'd3;

    localparam logic TGT_TMR = 1'b0;
    localparam logic TGT_RTC = 1'b1;

    localparam logic [7:0] OFS_PSTAT  = 8'h20;
    localparam logic [7:0] OFS_PMASK  = 8'h21;
    localparam logic [7:0] OFS_SSTAT  = 8'hA0;
    localparam logic [7:0] OFS_SMASK  = 8'hA1;
    localparam logic [7:0] OFS_TMR0   = 8'h40;
    localparam logic [7:0] OFS_TMR1   = 8'h41;
    localparam logic [7:0] OFS_TMR2   = 8'h42;
    localparam logic [7:0] OFS_TCTL   = 8'h43;
    localparam logic [7:0] OFS_RIDX   = 8'h70;
    localparam logic [7:0] OFS_RDATA  = 8'h71;
    localparam logic [7:0] OFS_PORTB  = 8'h61;
    localparam logic [7:0] OFS_KBD    = 8'h60;
    localparam logic [7:0] OFS_DMODE1 = 8'h0B;
    localparam logic [7:0] OFS_DMODE2 = 8'hD6;
    localparam logic [7:0] OFS_DCMD1  = 8'h08;
    localparam logic [7:0] OFS_DCMD2  = 8'hD0;
    localparam logic [7:0] OFS_DSMK1  = 8'h0A;
    localparam logic [7:0] OFS_DSMK2  = 8'hD4;
    localparam logic [7:0] OFS_DRST1  = 8'h0D;
    localparam logic [7:0] OFS_DRST2  = 8'hDA;
    localparam logic [7:0] OFS_DAMK1  = 8'h0F;
    localparam logic [7:0] OFS_DAMK2  = 8'hDE;

    localparam int SPKR_BIT  = 5;
    localparam int TCTL_IDX  = 3;

endpackage

// File: rtl/lio_decode.sv
module lio_decode
    import lio_pkg::*;
#(
    parameter int                ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE   = '0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              write,
    input  logic [1:0]        size,
    output kind_t             kind,
    output logic [1:0]        chan
);

    logic [7:0] ofs;
    logic       in_win;

    assign ofs    = addr[7:0];
    assign in_win = (addr[ADDR_W-1:8] == BASE[ADDR_W-1:8]);

    always_comb begin
        kind = AK_ERR;
        chan = ofs[1:0];
        if (!in_win) begin
            kind = AK_ERR;
        end else if (size == SZ_DWORD) begin
            kind = (!write && ofs == OFS_PSTAT) ? AK_PSTAT : AK_ERR;
        end else if (size == SZ_BYTE) begin
            case (ofs)
                OFS_PSTAT:  kind = write ? AK_PACK : AK_PSTAT;
                OFS_PMASK:  kind = AK_PMASK;
                OFS_SSTAT:  kind = write ? AK_DROP : AK_SSTAT;
                OFS_SMASK:  kind = AK_SMASK;
                OFS_TMR0,
                OFS_TMR1,
                OFS_TMR2:   kind = AK_TMR;
                OFS_TCTL:   kind = write ? AK_TCTL : AK_ERR;
                OFS_RIDX:   kind = write ? AK_RIDX : AK_ERR;
                OFS_RDATA:  kind = AK_RDATA;
                OFS_PORTB:  kind = write ? AK_DROP : AK_PORTB;
                OFS_DMODE1: kind = AK_DMODE1;
                OFS_DMODE2: kind = AK_DMODE2;
                OFS_KBD,
                OFS_DCMD1, OFS_DCMD2,
                OFS_DSMK1, OFS_DSMK2,
                OFS_DRST1, OFS_DRST2,
                OFS_DAMK1, OFS_DAMK2:
                            kind = write ? AK_DROP : AK_ERR;
                default:    kind = AK_ERR;
            endcase
        end else begin
            kind = AK_ERR;
        end
    end

endmodule

// File: rtl/lio_pend.sv
module lio_pend #(
    parameter int SRC_N = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_N-1:0] dev_set,
    input  logic [SRC_N-1:0] dev_clr,
    input  logic             ack_en,
    input  logic [3:0]       ack_idx,
    input  logic             mask_we,
    input  logic [SRC_N-1:0] mask_wdata,
    output logic [SRC_N-1:0] pend,
    output logic [SRC_N-1:0] en,
    output logic             irq
);

    logic [SRC_N-1:0] ack_clr;
    logic [SRC_N-1:0] pend_n;
    logic [SRC_N-1:0] en_n;

    for (genvar i = 0; i < SRC_N; i++) begin : g_ack
        assign ack_clr[i] = ack_en && (ack_idx == 4'(i));
    end

    always_comb begin
        pend_n = (pend | dev_set) & ~dev_clr & ~ack_clr;
        en_n   = mask_we ? ~mask_wdata : en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend <= '0;
            en   <= '0;
            irq  <= 1'b0;
        end else begin
            pend <= pend_n;
            en   <= en_n;
            irq  <= |(pend_n & en_n);
        end
    end

endmodule

// File: rtl/lio_ctl.sv
module lio_ctl
    import lio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  kind_t       kind,
    input  logic [1:0]  chan,
    input  logic [7:0]  req_wdata,
    input  logic [7:0]  rtc_idx,
    input  logic [7:0]  loc_rdata,
    input  logic        side_ack,
    input  logic [7:0]  side_rdata,
    output logic        req_ready,
    output logic        accept,
    output logic        side_req,
    output logic        side_tgt,
    output logic        side_we,
    output logic [7:0]  side_idx,
    output logic [7:0]  side_wdata,
    output logic        rsp_valid,
    output logic        rsp_err,
    output logic [63:0] rsp_rdata
);

    fsm_t       state;
    fsm_t       state_n;
    logic       is_side;
    logic [7:0] data_q;

    assign is_side = (kind == AK_TMR) || (kind == AK_TCTL) || (kind == AK_RDATA);
    assign accept  = req_valid && (state == ST_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // transitions
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: if (accept) state_n = is_side ? ST_SIDE : ST_RESP;
            ST_SIDE: if (side_ack) state_n = ST_RESP;
            ST_RESP: state_n = ST_IDLE;
            default: state_n = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready = (state == ST_IDLE);
        side_req  = (state == ST_SIDE);
        rsp_valid = (state == ST_RESP);
        rsp_rdata = {56'd0, data_q};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q     <= '0;
            rsp_err    <= 1'b0;
            side_tgt   <= TGT_TMR;
            side_we    <= 1'b0;
            side_idx   <= '0;
            side_wdata <= '0;
        end else if (accept) begin
            rsp_err    <= (kind == AK_ERR);
            data_q     <= (req_write || kind == AK_ERR) ? 8'h00 : loc_rdata;
            side_tgt   <= (kind == AK_RDATA) ? TGT_RTC : TGT_TMR;
            side_we    <= req_write;
            side_wdata <= req_wdata;
            if (kind == AK_RDATA)     side_idx <= rtc_idx;
            else if (kind == AK_TCTL) side_idx <= 8'(TCTL_IDX);
            else                      side_idx <= {6'd0, chan};
        end else if (state == ST_SIDE && side_ack && !side_we) begin
            data_q <= side_rdata;
        end
    end

endmodule

// File: rtl/lio_irq_agg.sv
module lio_irq_agg
    import lio_pkg::*;
#(
    parameter int                ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE   = 16'h0100,
    parameter int                SRC_N  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [7:0]        req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [63:0]       rsp_rdata,
    input  logic [SRC_N-1:0]  dev_set,
    input  logic [SRC_N-1:0]  dev_clr,
    output logic              irq_out,
    input  logic              tmr2_high,
    output logic              side_req,
    output logic              side_tgt,
    output logic              side_we,
    output logic [7:0]        side_idx,
    output logic [7:0]        side_wdata,
    input  logic              side_ack,
    input  logic [7:0]        side_rdata
);

    kind_t            kind;
    logic [1:0]       chan;
    logic             accept;
    logic             wr_acc;
    logic             pmask_we;
    logic             pack_en;
    logic [SRC_N-1:0] pend_q;
    logic [SRC_N-1:0] en_q;
    logic [7:0]       smask_q;
    logic [7:0]       mode1_q;
    logic [7:0]       mode2_q;
    logic [7:0]       rtc_idx_q;
    logic [7:0]       loc_rdata;

    lio_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
        .addr  (req_addr),
        .write (req_write),
        .size  (req_size),
        .kind  (kind),
        .chan  (chan)
    );

    assign wr_acc   = accept && req_write;
    assign pmask_we = wr_acc && (kind == AK_PMASK);
    assign pack_en  = wr_acc && (kind == AK_PACK);

    lio_pend #(.SRC_N(SRC_N)) u_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .dev_set    (dev_set),
        .dev_clr    (dev_clr),
        .ack_en     (pack_en),
        .ack_idx    (req_wdata[3:0]),
        .mask_we    (pmask_we),
        .mask_wdata (req_wdata[SRC_N-1:0]),
        .pend       (pend_q),
        .en         (en_q),
        .irq        (irq_out)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smask_q   <= '0;
            mode1_q   <= '0;
            mode2_q   <= '0;
            rtc_idx_q <= '0;
        end else if (wr_acc) begin
            if (kind == AK_SMASK)  smask_q   <= req_wdata;
            if (kind == AK_DMODE1) mode1_q   <= req_wdata;
            if (kind == AK_DMODE2) mode2_q   <= req_wdata;
            if (kind == AK_RIDX)   rtc_idx_q <= req_wdata;
        end
    end

    always_comb begin
        loc_rdata = 8'h00;
        case (kind)
            AK_PSTAT:  loc_rdata = 8'(pend_q);
            AK_PMASK:  loc_rdata = 8'(~en_q);
            AK_SMASK:  loc_rdata = smask_q;
            AK_PORTB:  loc_rdata = tmr2_high ? 8'(1 << SPKR_BIT) : 8'h00;
            AK_DMODE1: loc_rdata = mode1_q;
            AK_DMODE2: loc_rdata = mode2_q;
            default:   loc_rdata = 8'h00;
        endcase
    end

    lio_ctl u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .kind       (kind),
        .chan       (chan),
        .req_wdata  (req_wdata),
        .rtc_idx    (rtc_idx_q),
        .loc_rdata  (loc_rdata),
        .side_ack   (side_ack),
        .side_rdata (side_rdata),
        .req_ready  (req_ready),
        .accept     (accept),
        .side_req   (side_req),
        .side_tgt   (side_tgt),
        .side_we    (side_we),
        .side_idx   (side_idx),
        .side_wdata (side_wdata),
        .rsp_valid  (rsp_valid),
        .rsp_err    (rsp_err),
        .rsp_rdata  (rsp_rdata)
    );

endmodule

// File: rtl/lio_irq_agg_chk.sv
module lio_irq_agg_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_ready,
    input logic       rsp_valid,
    input logic       side_req,
    input logic       side_ack,
    input logic       side_tgt,
    input logic [7:0] side_idx,
    input logic [7:0] dev_set,
    input logic [7:0] dev_clr,
    input logic [7:0] pend,
    input logic [7:0] en,
    input logic       irq_out,
    input logic       mask_we,
    input logic       ack_en,
    input logic [3:0] ack_idx
);

    // R13
    rsp_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R13
    ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    // R13
    side_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (side_req && !side_ack) |=> (side_req && $stable(side_idx) && $stable(side_tgt)));

    // R5
    clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_clr != 8'h00) |=> ((pend & $past(dev_clr)) == 8'h00));

    // R4
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_en && !ack_idx[3] && !dev_set[ack_idx[2:0]]) |=> !pend[$past(ack_idx[2:0])]);

    // R3
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_out) |-> $past((dev_set != 8'h00) || mask_we));

    // R3
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en == 8'h00) |-> !irq_out);

endmodule

bind lio_irq_agg lio_irq_agg_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .side_req  (side_req),
    .side_ack  (side_ack),
    .side_tgt  (side_tgt),
    .side_idx  (side_idx),
    .dev_set   (dev_set),
    .dev_clr   (dev_clr),
    .pend      (pend_q),
    .en        (en_q),
    .irq_out   (irq_out),
    .mask_we   (pmask_we),
    .ack_en    (pack_en),
    .ack_idx   (req_wdata[3:0])
);

// File: tb/tb_lio_irq_agg.sv
module tb_lio_irq_agg;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [7:0]  req_wdata = '0;
    logic        rsp_valid;
    logic        rsp_err;
    logic [63:0] rsp_rdata;
    logic [7:0]  dev_set = '0;
    logic [7:0]  dev_clr = '0;
    logic        irq_out;
    logic        tmr2_high = 1'b0;
    logic        side_req;
    logic        side_tgt;
    logic        side_we;
    logic [7:0]  side_idx;
    logic [7:0]  side_wdata;
    logic        side_ack = 1'b0;
    logic [7:0]  side_rdata = '0;

    int nchk = 0;
    int nerr = 0;

    // side responder log
    int         side_cnt = 0;
    int         dly = 0;
    logic       lg_tgt, lg_we;
    logic [7:0] lg_idx, lg_wd;

    // model
    logic [7:0] pend_m = 8'h00;
    logic [7:0] en_m   = 8'h00;

    localparam logic [15:0] BASE = 16'h0100;

    always #2 clk = ~clk;

    lio_irq_agg dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .dev_set(dev_set), .dev_clr(dev_clr), .irq_out(irq_out),
        .tmr2_high(tmr2_high),
        .side_req(side_req), .side_tgt(side_tgt), .side_we(side_we),
        .side_idx(side_idx), .side_wdata(side_wdata),
        .side_ack(side_ack), .side_rdata(side_rdata)
    );

    always @(negedge clk) begin
        side_ack = 1'b0;
        if (side_req && !side_ack) begin
            if (dly == 1) begin
                side_ack   = 1'b1;
                side_rdata = 8'h30 + side_idx + (side_tgt ? 8'h80 : 8'h00);
                lg_tgt = side_tgt; lg_we = side_we; lg_idx = side_idx; lg_wd = side_wdata;
                side_cnt++;
                dly = 0;
            end else begin
                dly++;
            end
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic xact(input logic wr, input logic [15:0] a, input logic [1:0] sz,
                        input logic [7:0] wd, output logic [63:0] rd, output logic er);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        rd = 'x; er = 1'bx;
        for (int n = 0; n < 50; n++) begin
            if (rsp_valid) begin
                rd = rsp_rdata; er = rsp_err;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic rd8(input logic [7:0] ofs, output logic [63:0] rd, output logic er);
        xact(1'b0, BASE | 16'(ofs), 2'd0, 8'h00, rd, er);
    endtask

    task automatic wr8(input logic [7:0] ofs, input logic [7:0] d, output logic er);
        logic [63:0] rd;
        xact(1'b1, BASE | 16'(ofs), 2'd0, d, rd, er);
    endtask

    task automatic pulse(input logic [7:0] s, input logic [7:0] c);
        @(negedge clk);
        dev_set = s; dev_clr = c;
        @(negedge clk);
        dev_set = '0; dev_clr = '0;
        pend_m = (pend_m | s) & ~c;
    endtask

    function automatic logic rd_ok(input logic [7:0] o);
        return o inside {8'h20, 8'h21, 8'hA0, 8'hA1, 8'h40, 8'h41, 8'h42,
                         8'h71, 8'h61, 8'h0B, 8'hD6};
    endfunction

    function automatic logic wr_ok(input logic [7:0] o);
        return o inside {8'h20, 8'h21, 8'hA0, 8'hA1, 8'h40, 8'h41, 8'h42, 8'h43,
                         8'h70, 8'h71, 8'h61, 8'h60, 8'h08, 8'hD0, 8'h0A, 8'hD4,
                         8'h0F, 8'hDE, 8'h0D, 8'hDA, 8'h0B, 8'hD6};
    endfunction

    initial begin
        #(4 * 150000);
        nerr++; nchk++;
        $display("FAIL watchdog act=hung exp=done");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        logic [63:0] rd;
        logic        er;
        int          sc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        chk("R12 irq", 64'(irq_out), 64'd0);
        chk("R13 ready", 64'(req_ready), 64'd1);
        rd8(8'h21, rd, er); chk("R12 mask", rd, 64'hFF);
        rd8(8'h20, rd, er); chk("R12 pend", rd, 64'h00);
        rd8(8'h0B, rd, er); chk("R12 mode1", rd, 64'h00);
        rd8(8'hD6, rd, er); chk("R12 mode2", rd, 64'h00);
        rd8(8'h71, rd, er); chk("R12 rtcidx", 64'(lg_idx), 64'h00);

        // R1 read sweep over the whole window
        for (int o = 0; o < 256; o++) begin
            rd8(8'(o), rd, er);
            chk($sformatf("R1 rd err ofs %02h", o), 64'(er), 64'(!rd_ok(8'(o))));
        end
        // R1 write sweep with zero data (benign: ack idx 0 with empty pend, mask enables all)
        for (int o = 0; o < 256; o++) begin
            wr8(8'(o), 8'h00, er);
            chk($sformatf("R1 wr err ofs %02h", o), 64'(er), 64'(!wr_ok(8'(o))));
        end
        en_m = 8'hFF;
        // restore defaults
        wr8(8'h21, 8'hFF, er); en_m = 8'h00;

        // R1 out of window, no state change
        xact(1'b1, 16'h0221, 2'd0, 8'h00, rd, er);
        chk("R1 outside err", 64'(er), 64'd1);
        rd8(8'h21, rd, er); chk("R1 outside no effect", rd, 64'hFF);

        // R6 size handling
        pulse(8'h5A, 8'h00);
        xact(1'b0, BASE | 16'h20, 2'd3, 8'h00, rd, er);
        chk("R6 dword data", rd, 64'h5A); chk("R6 dword err", 64'(er), 64'd0);
        xact(1'b0, BASE | 16'h21, 2'd3, 8'h00, rd, er); chk("R6 dword mask err", 64'(er), 64'd1);
        xact(1'b1, BASE | 16'h20, 2'd3, 8'h00, rd, er); chk("R6 dword wr err", 64'(er), 64'd1);
        xact(1'b0, BASE | 16'h20, 2'd1, 8'h00, rd, er); chk("R6 size1 err", 64'(er), 64'd1);
        xact(1'b0, BASE | 16'h20, 2'd2, 8'h00, rd, er); chk("R6 size2 err", 64'(er), 64'd1);
        rd8(8'h20, rd, er); chk("R6 byte pend", rd, 64'h5A);
        chk("R3 irq masked", 64'(irq_out), 64'd0);

        // R2/R3 mask sweep
        for (int m = 0; m < 256; m += 17) begin
            wr8(8'h21, 8'(m), er); en_m = ~8'(m);
            rd8(8'h21, rd, er); chk("R2 mask readback", rd, 64'(m));
            chk("R3 irq vs mask", 64'(irq_out), 64'(|(pend_m & en_m)));
        end

        // R5 set/clear and clear priority
        wr8(8'h21, 8'h00, er); en_m = 8'hFF;
        pulse(8'h00, 8'hFF);
        chk("R3 irq off", 64'(irq_out), 64'd0);
        pulse(8'h81, 8'h00);
        chk("R3 irq on", 64'(irq_out), 64'd1);
        pulse(8'hFF, 8'h0F);
        rd8(8'h20, rd, er); chk("R5 clr wins", rd, 64'hF0);
        pulse(8'h00, 8'h30);
        rd8(8'h20, rd, er); chk("R5 clr", rd, 64'(pend_m));

        // R4 ack sweep
        for (int i = 0; i < 16; i++) begin
            pulse(8'hFF, 8'h00);
            wr8(8'h20, 8'(i) | 8'hA0, er);
            if (i < 8) pend_m[i] = 1'b0;
            rd8(8'h20, rd, er); chk($sformatf("R4 ack %0d", i), rd, 64'(pend_m));
        end
        for (int i = 0; i < 8; i++) wr8(8'h20, 8'(i), er);
        pend_m = 8'h00;
        chk("R3 irq after acks", 64'(irq_out), 64'd0);

        // R7 secondary
        pulse(8'h04, 8'h00);
        wr8(8'h21, 8'hFF, er); en_m = 8'h00;
        wr8(8'hA1, 8'h00, er);
        chk("R7 smask no irq", 64'(irq_out), 64'd0);
        wr8(8'hA1, 8'h3C, er);
        rd8(8'hA1, rd, er); chk("R7 smask rb", rd, 64'h3C);
        rd8(8'hA0, rd, er); chk("R7 sstat zero", rd, 64'h00);

        // R8 port B
        tmr2_high = 1'b1;
        rd8(8'h61, rd, er); chk("R8 high", rd, 64'h20);
        wr8(8'h61, 8'hFF, er);
        tmr2_high = 1'b0;
        rd8(8'h61, rd, er); chk("R8 low after write", rd, 64'h00);

        // R9 RTC
        wr8(8'h70, 8'h0C, er);
        rd8(8'h71, rd, er);
        chk("R9 rd data", rd, 64'(8'h30 + 8'h0C + 8'h80));
        chk("R9 tgt", 64'(lg_tgt), 64'd1); chk("R9 idx", 64'(lg_idx), 64'h0C);
        chk("R9 we", 64'(lg_we), 64'd0);
        wr8(8'h71, 8'h77, er);
        chk("R9 wr we", 64'(lg_we), 64'd1); chk("R9 wr data", 64'(lg_wd), 64'h77);

        // R10 timer
        for (int c = 0; c < 3; c++) begin
            rd8(8'h40 + 8'(c), rd, er);
            chk("R10 tmr data", rd, 64'(8'h30 + 8'(c)));
            chk("R10 tmr idx", 64'(lg_idx), 64'(c));
            chk("R10 tmr tgt", 64'(lg_tgt), 64'd0);
        end
        wr8(8'h43, 8'h36, er);
        chk("R10 ctrl idx", 64'(lg_idx), 64'd3); chk("R10 ctrl data", 64'(lg_wd), 64'h36);

        // R11 discards and modes
        sc = side_cnt;
        wr8(8'h0B, 8'h55, er); wr8(8'hD6, 8'hAA, er);
        wr8(8'h08, 8'hFF, er); wr8(8'hD0, 8'hFF, er); wr8(8'h0D, 8'hFF, er);
        wr8(8'h60, 8'hFF, er); wr8(8'hDE, 8'hFF, er); wr8(8'hA0, 8'hFF, er);
        chk("R11 discard err", 64'(er), 64'd0);
        chk("R11 no side", 64'(side_cnt), 64'(sc));
        rd8(8'h0B, rd, er); chk("R11 mode1", rd, 64'h55);
        rd8(8'hD6, rd, er); chk("R11 mode2", rd, 64'hAA);
        rd8(8'h20, rd, er); chk("R11 pend kept", rd, 64'(pend_m));
        rd8(8'h21, rd, er); chk("R11 mask kept", rd, 64'hFF);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule